// File: doc/BRIEF.md
# Mailbox Handshake Responder

This block is the controller-side end of a byte-wide mailbox that a host reaches through two adjacent ports. Port 0 holds a register index. Port 1 moves a byte to or from the register that index selects. Most indices are plain byte storage. Three indices have a role in a handshake:

- a command index (0x80);
- a response index (0x82);
- an ownership-flag index (0x83).

To make a request, the host writes a flag byte and clears the response register. It then writes the go code 0x96 to the command index. The responder decides the outcome from the flag held at that moment. It then waits a parameterised number of cycles. At the end of that wait it updates its `parked` output and writes a completion byte into the response register. The host polls the response register for that byte.

A flag of 0xB4 asks the responder to park its own bus activity. A flag of 0xB5 lets it resume. Both requests share the one go code. A command byte other than 0x96, or a flag other than the two legal values, is refused with a reject byte. A refused request leaves `parked` unchanged.

Top module: `mbx_responder`

## Requirements
- R1: After a synchronous active-high reset, `parked` is 0, the index register reads back 0x00 on port 0, and the response register (index 0x82) reads back 0x00.
- R2: A write on port 0 (`port_sel`=0) loads the index register. A read is sampled at a clock edge, and its byte appears on `rdata` from that edge until the next read. A port 0 read returns the index register.
- R3: A write on port 1 (`port_sel`=1) stores the byte at the current index. A port 1 read at any index other than 0x82 returns the byte last written there, including indices 0x80 and 0x83.
- R4: If 0x96 is written to index 0x80 at edge E while the flag register holds 0xB4, then at edge E+LATENCY `parked` becomes 1 and the response register becomes 0xFA. Neither changes before that edge.
- R5: The same command with flag 0xB5 drives `parked` to 0 and writes 0xFA at edge E+LATENCY.
- R6: Any byte other than 0x96 written to index 0x80 still runs the timer. At edge E+LATENCY it writes 0xFF to the response register and leaves `parked` unchanged.
- R7: A 0x96 command with a flag value other than 0xB4 or 0xB5 writes 0xFF at edge E+LATENCY and leaves `parked` unchanged.
- R8: A write to index 0x80 at edges E+1 through E+LATENCY, while a command is pending, starts no new command. The byte is still stored.
- R9: The outcome is fixed by the flag held at edge E. A flag write during the wait has no effect on the outcome, though it still reads back.
- R10: The host can write the response register through port 1 and read the byte back. A completion write in the same cycle takes priority over the host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe for the selected port (not asserted together with wr_en) |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte from the last read, registered |
| parked | output | 1 | 1 while the responder has yielded its bus activity |

## Verification
A wrong pending outcome or a miscounted timer is visible at the ports in two ways:

- the host's poll of the response register ends on the wrong poll;
- the poll ends on the wrong completion byte.

The bench therefore checks the exact poll count, which the fixed latency determines, as well as the byte. A corrupted `parked` state or a stale flag capture appears on `parked` at the completion edge of the same request. A bad index or storage path shows up on the very next read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t IDX_CMD     = 8'h80;
  localparam byte_t IDX_RESP    = 8'h82;
  localparam byte_t IDX_FLAG    = 8'h83;
  localparam byte_t CODE_GO     = 8'h96;
  localparam byte_t FLAG_YIELD  = 8'hB4;
  localparam byte_t FLAG_RETURN = 8'hB5;
  localparam byte_t RESP_DONE   = 8'hFA;
  localparam byte_t RESP_REJECT = 8'hFF;

  typedef enum logic [1:0] {VERD_YIELD, VERD_RETURN, VERD_REJECT} verdict_e;
  typedef enum logic [1:0] {SRC_INDEX, SRC_RESP, SRC_FLAG, SRC_MEM} rd_src_e;
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import mbx_pkg::*;
(
  input  byte_t    code_i,
  input  byte_t    flag_i,
  output verdict_e verdict_o
);
  always_comb begin
    verdict_o = VERD_REJECT;
    if (code_i == CODE_GO) begin
      if (flag_i == FLAG_YIELD)       verdict_o = VERD_YIELD;
      else if (flag_i == FLAG_RETURN) verdict_o = VERD_RETURN;
    end
  end
endmodule

// File: rtl/mbx_resp_timer.sv
module mbx_resp_timer
  import mbx_pkg::*;
#(
  parameter int LATENCY = 20
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start_i,
  input  verdict_e verdict_i,
  output logic     done_o,
  output byte_t    done_code_o,
  output logic     parked_o
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  verdict_e         verd_q;
  logic             parked_q;

  assign done_o      = busy_q && (cnt_q == CNT_W'(0));
  assign done_code_o = (verd_q == VERD_REJECT) ? RESP_REJECT : RESP_DONE;
  assign parked_o    = parked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      verd_q   <= VERD_REJECT;
      parked_q <= 1'b0;
    end else begin
      if (done_o) begin
        busy_q <= 1'b0;
        case (verd_q)
          VERD_YIELD:  parked_q <= 1'b1;
          VERD_RETURN: parked_q <= 1'b0;
          default:     parked_q <= parked_q;
        endcase
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(LATENCY - 1);
        verd_q <= verdict_i;
      end
    end
  end

  // R4: parked moves only at a completion edge
  a_r4_parked_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(parked_q) |-> $past(done_o));
  // R4: an accepted command enters the waiting state
  a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |=> busy_q);
  // R8 / R9: the pending outcome is frozen until completion
  a_r9_verdict_held: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_o) |=> $stable(verd_q));
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             port_sel,
  input  byte_t            wdata,
  input  logic             done_i,
  input  byte_t            done_code_i,
  output logic [IDX_W-1:0] idx_o,
  output byte_t            flag_o,
  output byte_t            rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  byte_t            mem [DEPTH];
  byte_t            mem_q;
  logic [IDX_W-1:0] idx_q, idx_snap;
  byte_t            flag_q, resp_q, flag_snap, resp_snap;
  rd_src_e          src_q;

  logic host_idx_wr, host_data_wr;
  assign host_idx_wr  = wr_en && !port_sel;
  assign host_data_wr = wr_en && port_sel;
  assign idx_o  = idx_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk) begin
    if (host_data_wr) mem[idx_q] <= wdata;
    if (rd_en)        mem_q      <= mem[idx_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      flag_q <= '0;
      resp_q <= '0;
    end else begin
      if (host_idx_wr) idx_q <= wdata[IDX_W-1:0];
      if (host_data_wr && idx_q == IDX_W'(IDX_FLAG)) flag_q <= wdata;
      if (done_i)
        resp_q <= done_code_i;
      else if (host_data_wr && idx_q == IDX_W'(IDX_RESP))
        resp_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= SRC_INDEX;
      idx_snap  <= '0;
      flag_snap <= '0;
      resp_snap <= '0;
    end else if (rd_en) begin
      idx_snap  <= idx_q;
      flag_snap <= flag_q;
      resp_snap <= resp_q;
      if (!port_sel)                       src_q <= SRC_INDEX;
      else if (idx_q == IDX_W'(IDX_RESP))  src_q <= SRC_RESP;
      else if (idx_q == IDX_W'(IDX_FLAG))  src_q <= SRC_FLAG;
      else                                 src_q <= SRC_MEM;
    end
  end

  always_comb begin
    case (src_q)
      SRC_INDEX: rdata_o = byte_t'(idx_snap);
      SRC_RESP:  rdata_o = resp_snap;
      SRC_FLAG:  rdata_o = flag_snap;
      default:   rdata_o = mem_q;
    endcase
  end

  // R2: an index-port write lands in the index register
  a_r2_index_capture: assert property (@(posedge clk) disable iff (rst)
    host_idx_wr |=> idx_q == $past(wdata[IDX_W-1:0]));
  // R10: a completion write reaches the response register, whatever the host does
  a_r10_done_wins: assert property (@(posedge clk) disable iff (rst)
    done_i |=> resp_q == $past(done_code_i));
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
  import mbx_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int LATENCY = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       port_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       parked
);
  logic [IDX_W-1:0] idx;
  byte_t            flag, done_code;
  logic             done, cmd_wr;
  verdict_e         verdict;

  assign cmd_wr = wr_en && port_sel && (idx == IDX_W'(IDX_CMD));

  mbx_regfile #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
    .wdata(wdata), .done_i(done), .done_code_i(done_code),
    .idx_o(idx), .flag_o(flag), .rdata_o(rdata)
  );

  mbx_cmd_decode u_dec (
    .code_i(wdata), .flag_i(flag), .verdict_o(verdict)
  );

  mbx_resp_timer #(.LATENCY(LATENCY)) u_timer (
    .clk(clk), .rst(rst), .start_i(cmd_wr), .verdict_i(verdict),
    .done_o(done), .done_code_o(done_code), .parked_o(parked)
  );
endmodule

// File: tb/mbx_responder_test.sv
module mbx_responder_test;
  localparam int LAT = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic parked;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic trk_drv = 1'b0, trk_seen = 1'b0;
  bit finished = 1'b0;

  mbx_responder #(.LATENCY(LAT)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
    .wdata(wdata), .rdata(rdata), .parked(parked)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte per tracked read
  always @(posedge clk) trk_seen <= rst ? 1'b0 : (rd_en && trk_drv);
  always @(negedge clk) begin
    if (trk_seen) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", rdata, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
  end

  task automatic op(input logic we, input logic re, input logic sel,
                    input logic [7:0] d, input logic trk);
    wr_en = we; rd_en = re; port_sel = sel; wdata = d; trk_drv = trk;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_idx(input logic [7:0] i); op(1, 0, 0, i, 0); endtask
  task automatic put(input logic [7:0] d);     op(1, 0, 1, d, 0); endtask
  task automatic expect_data(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t); op(0, 1, 1, 8'h00, 1);
  endtask
  task automatic expect_idx(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t); op(0, 1, 0, 8'h00, 1);
  endtask

  task automatic poll(output int n, output logic [7:0] resp);
    n = 0;
    do begin
      op(0, 1, 1, 8'h00, 0);
      n++;
    end while (rdata == 8'h00 && n < 500);
    resp = rdata;
  endtask

  // full request: flag, clear response, command, then poll; pre = parked just after command
  task automatic run_cmd(input logic [7:0] flag, input logic [7:0] code,
                         output int n, output logic [7:0] resp, output logic pre);
    set_idx(8'h83); put(flag);
    set_idx(8'h82); put(8'h00);
    set_idx(8'h80); put(code);
    set_idx(8'h82);
    pre = parked;
    poll(n, resp);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    int n;
    logic [7:0] resp;
    logic pre;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(parked == 1'b0, "R1 parked after reset", parked, 0);
    expect_idx(8'h00, "R1 index after reset");
    set_idx(8'h82);
    expect_data(8'h00, "R1 response after reset");

    // R2 index port
    set_idx(8'h5A);
    expect_idx(8'h5A, "R2 index readback");

    // R3 plain storage
    put(8'hC3);
    set_idx(8'h10); put(8'h3C);
    expect_data(8'h3C, "R3 storage at 0x10");
    set_idx(8'h5A);
    expect_data(8'hC3, "R3 storage at 0x5A");

    // R10 host write to response register
    set_idx(8'h82); put(8'h5C);
    expect_data(8'h5C, "R10 response host write");

    // R4 yield
    run_cmd(8'hB4, 8'h96, n, resp, pre);
    check(pre == 1'b0, "R4 parked before completion", pre, 0);
    check(n == LAT, "R4 poll count", n, LAT);
    check(resp == 8'hFA, "R4 done code", resp, 8'hFA);
    check(parked == 1'b1, "R4 parked set", parked, 1);

    // R6 unknown command while parked
    run_cmd(8'hB4, 8'h42, n, resp, pre);
    check(n == LAT, "R6 poll count", n, LAT);
    check(resp == 8'hFF, "R6 reject code", resp, 8'hFF);
    check(parked == 1'b1, "R6 parked unchanged", parked, 1);

    // R5 release
    run_cmd(8'hB5, 8'h96, n, resp, pre);
    check(pre == 1'b1, "R5 parked before completion", pre, 1);
    check(n == LAT, "R5 poll count", n, LAT);
    check(resp == 8'hFA, "R5 done code", resp, 8'hFA);
    check(parked == 1'b0, "R5 parked cleared", parked, 0);

    // R7 illegal flag
    run_cmd(8'h11, 8'h96, n, resp, pre);
    check(resp == 8'hFF, "R7 reject code", resp, 8'hFF);
    check(parked == 1'b0, "R7 parked unchanged", parked, 0);

    // R8 / R9: command and flag writes during the wait
    set_idx(8'h83); put(8'hB4);
    set_idx(8'h82); put(8'h00);
    set_idx(8'h80); put(8'h96);   // accepted at edge E
    put(8'h33);                   // E+1: ignored as command
    set_idx(8'h83); put(8'h11);   // E+3: flag change during wait
    set_idx(8'h82);
    poll(n, resp);
    check(n == LAT - 3, "R8 poll count unchanged by busy write", n, LAT - 3);
    check(resp == 8'hFA, "R9 outcome uses captured flag", resp, 8'hFA);
    check(parked == 1'b1, "R9 parked from captured flag", parked, 1);
    set_idx(8'h83);
    expect_data(8'h11, "R9 flag readback");
    set_idx(8'h80);
    expect_data(8'h33, "R8 command byte stored");

    op(0, 0, 0, 8'h00, 0);
    op(0, 0, 0, 8'h00, 0);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    summary();
  end
endmodule